// File: doc/BRIEF.md
# Serial Configuration Port

This block receives configuration words over a three-wire, write-only serial link (serial clock, serial data, active-low enable) and keeps them in five configuration registers of different widths. Every register field is driven as a parallel output to the analog front end that it configures. The registers cover a drain-level setting, two bandwidth codes, a gain code, a set of power-down and pulse-polarity flags, and a clamp reference level.

The three serial inputs are treated as asynchronous. They pass through synchronizers into the fast core clock, and the edges of the serial clock and the enable are detected there. Each frame has 13 bits: a 3-bit register select, then a 10-bit payload. A frame takes effect only when the enable is released, and only if exactly 13 bits were clocked in while the enable was low.

Top module: `serial_cfg_port`

## Requirements
- R1: Serial-clock rising edges that occur while the enable input is high are ignored and add no bits to the next frame.
- R2: A frame is 13 bits, sampled on serial-clock rising edges and sent most significant bit first: select bits S2,S1,S0 first, then payload bits P9 down to P0.
- R3: Select 000 loads `drain_lvl` from P7..P0. P9 and P8 are ignored.
- R4: Select 001 loads `bw_samp` from P3..P0 and `bw_gain` from P7..P4.
- R5: Select 010 loads the 9-bit `gain_code` from P8..P0.
- R6: Select 011 loads the flags: P0 drives `stby_front`, P1 drives `stby_drain`, P2 drives `stby_amp`, P3 drives `samp_fall` (sample pulses act on their falling edge), P4 drives `clamp_hi` (clamp pulses active high), and P5 drives `conv_rise` (when it is 0 the converter clock acts on its falling edge). P9..P6 are ignored.
- R7: Select 100 loads the 10-bit `clamp_ref` from P9..P0.
- R8: A register changes only when the enable rises, and only if exactly 13 bits were received. Frames of 12 or 14 bits leave every register unchanged, and so does a full frame while the enable is still low.
- R9: Selects 101, 110 and 111 leave every register unchanged.
- R10: After reset every output is zero, so no block is in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data |
| ser_en_n | input | 1 | Frame enable, active low; its rising edge commits the frame |
| drain_lvl | output | 8 | Drain-level setting |
| bw_samp | output | 4 | Sampling-stage bandwidth code |
| bw_gain | output | 4 | Gain-stage bandwidth code |
| gain_code | output | 9 | Amplifier gain code |
| stby_front | output | 1 | Sampling and gain stages powered down |
| stby_drain | output | 1 | Drain-level converter powered down |
| stby_amp | output | 1 | Fixed-gain amplifier powered down |
| samp_fall | output | 1 | Sample pulses act on their falling edge |
| clamp_hi | output | 1 | Clamp pulses are active high |
| conv_rise | output | 1 | Converter clock acts on its rising edge |
| clamp_ref | output | 10 | Clamp reference level |

## Verification
On every cycle, the assertions check four things: the bit counter stays inside its saturating range, the counter stays at zero while the enable is high, no register moves except in the cycle after an enable release, and a release with a wrong bit count or an unused select changes nothing. Only the bench scenarios can show that each select routes each payload bit to the right field in the right order. The same goes for clock pulses sent before a frame, which must leave no stray bits behind, and for short and long frames, which must be dropped as whole frames.

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_dat,
  input  logic        ser_en_n,
  output logic [7:0]  drain_lvl,
  output logic [3:0]  bw_samp,
  output logic [3:0]  bw_gain,
  output logic [8:0]  gain_code,
  output logic        stby_front,
  output logic        stby_drain,
  output logic        stby_amp,
  output logic        samp_fall,
  output logic        clamp_hi,
  output logic        conv_rise,
  output logic [9:0]  clamp_ref
);
  localparam int SEL_W = 3;
  localparam int PAY_W = 10;
  localparam int FRAME = SEL_W + PAY_W;
  localparam int CNT_W = $clog2(FRAME + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME + 1);

  logic [SYNC_STAGES-1:0] ck_s, dt_s, en_s;
  logic                   ck_p, en_p;
  logic [FRAME-1:0]       shreg;
  logic [CNT_W-1:0]       cnt;

  wire ck_rise = ck_s[SYNC_STAGES-1] & ~ck_p;
  wire en_high = en_s[SYNC_STAGES-1];
  wire en_rise = en_high & ~en_p;
  wire [SEL_W-1:0] sel = shreg[FRAME-1:PAY_W];
  wire [PAY_W-1:0] pay = shreg[PAY_W-1:0];
  wire commit = en_rise && (cnt == CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_s <= '0;
      dt_s <= '0;
      en_s <= '1;
      ck_p <= 1'b0;
      en_p <= 1'b1;
    end else begin
      ck_s <= {ck_s[SYNC_STAGES-2:0], ser_clk};
      dt_s <= {dt_s[SYNC_STAGES-2:0], ser_dat};
      en_s <= {en_s[SYNC_STAGES-2:0], ser_en_n};
      ck_p <= ck_s[SYNC_STAGES-1];
      en_p <= en_high;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (en_high) begin
      cnt <= '0;
    end else if (ck_rise) begin
      shreg <= {shreg[FRAME-2:0], dt_s[SYNC_STAGES-1]};
      if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_lvl  <= '0;
      bw_samp    <= '0;
      bw_gain    <= '0;
      gain_code  <= '0;
      stby_front <= 1'b0;
      stby_drain <= 1'b0;
      stby_amp   <= 1'b0;
      samp_fall  <= 1'b0;
      clamp_hi   <= 1'b0;
      conv_rise  <= 1'b0;
      clamp_ref  <= '0;
    end else if (commit) begin
      case (sel)
        3'd0: drain_lvl <= pay[7:0];
        3'd1: begin
          bw_samp <= pay[3:0];
          bw_gain <= pay[7:4];
        end
        3'd2: gain_code <= pay[8:0];
        3'd3: begin
          stby_front <= pay[0];
          stby_drain <= pay[1];
          stby_amp   <= pay[2];
          samp_fall  <= pay[3];
          clamp_hi   <= pay[4];
          conv_rise  <= pay[5];
        end
        3'd4: clamp_ref <= pay;
        default: ;
      endcase
    end
  end

  wire [40:0] regs = {drain_lvl, bw_samp, bw_gain, gain_code, stby_front, stby_drain,
                      stby_amp, samp_fall, clamp_hi, conv_rise, clamp_ref};

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_OVER); // R2
  AST_IDLE_NO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    en_high |=> cnt == '0); // R1
  AST_ONLY_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_rise |=> $stable(regs)); // R8
  AST_BAD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && cnt != CNT_FULL) |=> $stable(regs)); // R8
  AST_UNUSED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && sel > 3'd4) |=> $stable(regs)); // R9
endmodule

// File: tb/serial_cfg_port_tb.sv
module serial_cfg_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en_n = 1'b1;
  logic [7:0] drain_lvl;
  logic [3:0] bw_samp, bw_gain;
  logic [8:0] gain_code;
  logic stby_front, stby_drain, stby_amp, samp_fall, clamp_hi, conv_rise;
  logic [9:0] clamp_ref;

  always #2.5 clk = ~clk;

  serial_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en_n(ser_en_n),
    .drain_lvl(drain_lvl), .bw_samp(bw_samp), .bw_gain(bw_gain), .gain_code(gain_code),
    .stby_front(stby_front), .stby_drain(stby_drain), .stby_amp(stby_amp),
    .samp_fall(samp_fall), .clamp_hi(clamp_hi), .conv_rise(conv_rise), .clamp_ref(clamp_ref)
  );

  int tests = 0, fails = 0;
  bit finished = 1'b0;
  logic [40:0] exp_q[$];
  string tag_q[$];
  event frame_done;

  logic [7:0] m_drain = '0;
  logic [3:0] m_bws = '0, m_bwg = '0;
  logic [8:0] m_gain = '0;
  logic [5:0] m_flags = '0;
  logic [9:0] m_clamp = '0;

  function automatic logic [40:0] dut_vec();
    return {drain_lvl, bw_samp, bw_gain, gain_code, stby_front, stby_drain,
            stby_amp, samp_fall, clamp_hi, conv_rise, clamp_ref};
  endfunction

  function automatic logic [40:0] model_vec();
    return {m_drain, m_bws, m_bwg, m_gain, m_flags[0], m_flags[1], m_flags[2],
            m_flags[3], m_flags[4], m_flags[5], m_clamp};
  endfunction

  task automatic check(string tag, logic [40:0] act, logic [40:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(logic [15:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = v[i];
      wait_clk(6);
      ser_clk = 1'b1;
      wait_clk(6);
      ser_clk = 1'b0;
    end
  endtask

  // Sends n bits of v (MSB first), releases enable, pushes the expected state.
  task automatic send(logic [15:0] v, int n, string tag);
    logic [2:0] s;
    logic [9:0] p;
    @(negedge clk);
    ser_en_n = 1'b0;
    wait_clk(6);
    shift_bits(v, n);
    wait_clk(12);
    if (n == 13) check({tag, " before release (R8)"}, dut_vec(), model_vec());
    ser_en_n = 1'b1;
    if (n == 13) begin
      s = v[12:10];
      p = v[9:0];
      case (s)
        3'd0: m_drain = p[7:0];
        3'd1: begin m_bws = p[3:0]; m_bwg = p[7:4]; end
        3'd2: m_gain = p[8:0];
        3'd3: m_flags = p[5:0];
        3'd4: m_clamp = p;
        default: ;
      endcase
    end
    exp_q.push_back(model_vec());
    tag_q.push_back(tag);
    wait_clk(12);
    -> frame_done;
    wait_clk(4);
  endtask

  initial begin
    forever begin
      @(frame_done);
      @(negedge clk);
      if (exp_q.size() > 0) check(tag_q.pop_front(), dut_vec(), exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    check("R10 reset state", dut_vec(), '0);
    rst_n = 1'b1;
    wait_clk(5);
    check("R10 after reset release", dut_vec(), '0);

    send({3'b000, 10'h3A5}, 13, "R3 drain level, P9..P8 ignored");
    send({3'b001, 10'h0C7}, 13, "R4 bandwidth codes");
    send({3'b010, 10'h1B3}, 13, "R5 gain code");
    send({3'b011, 10'h3D5}, 13, "R6 flags pattern A");
    send({3'b011, 10'h02A}, 13, "R6 flags pattern B");
    send({3'b100, 10'h2E9}, 13, "R7 clamp reference");
    send({3'b100, 10'h001}, 13, "R2 bit order LSB only");
    send({3'b101, 10'h3FF}, 13, "R9 select 101 ignored");
    send({3'b110, 10'h155}, 13, "R9 select 110 ignored");
    send({3'b111, 10'h2AA}, 13, "R9 select 111 ignored");
    send({3'b000, 10'h0FF}, 12, "R8 short frame dropped");
    send({3'b000, 10'h0FF, 1'b1}, 14, "R8 long frame dropped");

    // R1: clock pulses with enable high must not leave stray bits
    ser_dat = 1'b1;
    for (int k = 0; k < 3; k++) begin
      wait_clk(6); ser_clk = 1'b1; wait_clk(6); ser_clk = 1'b0;
    end
    send({3'b010, 10'h04C}, 13, "R1 idle clocks ignored");
    send({3'b001, 10'h05A}, 13, "R2 second bandwidth write");

    wait_clk(10);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule